// File: doc/BRIEF.md
# Converter Clock Selection and Conversion Sequencer

This block paces a successive-approximation converter. At the start of each conversion it records the clock source, the divide ratio and the sampling length. A conversion starts on a software control write, on a hardware trigger, or from continuous mode. The block counts bus cycles and conversion-clock periods until the required latency has passed. It then raises a one-cycle done pulse and hands the sample from a behavioural converter stub to the downstream result or compare logic.

The whole block runs in the bus clock domain. The alternate clock and the internal asynchronous clock arrive as single-cycle strobes that are already synchronised to the bus clock. The bus clock and half the bus clock are derived inside the block. A wait-mode input limits which events may start a conversion and which sources may run while the system sleeps.

Top module: `adc_conv_seq`

## Requirements
- R1: `clk_sel_i` picks the conversion source: 0 is every bus cycle, 1 is every second bus cycle, 2 is the `alt_tick_i` strobe and 3 is the `async_tick_i` strobe. `div_sel_i` values 0, 1, 2 and 3 divide that source by 1, 2, 4 and 8 to form the conversion clock.
- R2: A first or single conversion spends 5 bus cycles on synchronisation after the start edge. It then spends 23 conversion-clock periods. For source 0 and ratio D, `done_o` is high after edge 5+23·D counted from the start edge.
- R3: In continuous mode, each following conversion starts directly after the previous done edge, with no synchronisation. It lasts 40 conversion-clock periods when `long_smp_i` is 1 and 20 when it is 0. When `cont_i` is low at a done edge, the block goes idle.
- R4: `done_o` is high for exactly one bus cycle. At that same edge, `result_o` captures `sample_i` and holds it until the next done.
- R5: A software start is a `ctrl_wr_i` pulse with `chan_valid_i`=1, `hw_trig_en_i`=0 and `wait_i`=0.
- R6: A control write outside wait mode aborts a running conversion. It restarts the conversion from zero when the conditions of R5 hold. Otherwise the block goes idle and no done follows.
- R7: When `hw_trig_en_i`=1, a `trig_i` pulse starts a conversion if the block is idle and `chan_valid_i`=1. A control write does not start a conversion while `hw_trig_en_i`=1.
- R8: A conversion that is running when `wait_i` rises runs to its done at the normal time.
- R9: While `wait_i`=1, control writes have no effect. Only a hardware trigger or a continuous chain may begin a conversion.
- R10: While `wait_i`=1, source 2 may only be used if `alt_wait_ok_i`=1. Otherwise a trigger selecting it is ignored, and a continuous chain on it ends at its next done.
- R11: After reset, `busy_o`, `done_o` and `result_o` are all zero.
- R12: Source, divide and sampling length are captured at the start edge. Changing them during a conversion does not change its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| alt_tick_i | input | 1 | Alternate clock strobe, bus-synchronous |
| async_tick_i | input | 1 | Internal asynchronous clock strobe, bus-synchronous |
| wait_i | input | 1 | System in wait mode |
| alt_wait_ok_i | input | 1 | Alternate source allowed in wait mode |
| clk_sel_i | input | 2 | Conversion clock source select |
| div_sel_i | input | 2 | Divide ratio select (1, 2, 4, 8) |
| long_smp_i | input | 1 | Long sampling for continuous follow-on conversions |
| cont_i | input | 1 | Continuous conversion mode |
| hw_trig_en_i | input | 1 | Hardware trigger mode |
| chan_valid_i | input | 1 | An input channel is selected |
| ctrl_wr_i | input | 1 | Control register write strobe |
| trig_i | input | 1 | Hardware trigger pulse |
| sample_i | input | SMP_W | Value returned by the converter stub |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle conversion complete pulse |
| result_o | output | SMP_W | Sample captured at done |

## Verification
The bench builds the block with its defaults: a 12-bit sample, 23 first-conversion periods, 40 and 20 follow-on periods, 5 synchronisation cycles and a 2-bit divide select. With these values, all sixteen source and divide pairs complete within about 925 bus cycles, so every pair can be timed exactly, including divide-by-8 on the slowest strobe. The alternate and asynchronous strobes come every 3 and 5 cycles, counted from the start edge. Their latencies therefore depend on strobe phase, which exposes any off-by-one in the divider or the synchronisation window.

// File: rtl/adc_seq_pkg.sv
// Shared encodings for the conversion sequencer.
// Assumes a 2-bit divide select, giving ratios 1, 2, 4 and 8.
package adc_seq_pkg;

    localparam int DIV_SEL_W = 2;

    typedef enum logic [1:0] {
        SRC_BUS   = 2'd0,
        SRC_HALF  = 2'd1,
        SRC_ALT   = 2'd2,
        SRC_ASYNC = 2'd3
    } src_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_CONV = 2'd2
    } seq_state_e;

    typedef struct packed {
        src_sel_e               src;
        logic [DIV_SEL_W-1:0]   div;
        logic                   long_smp;
    } conv_cfg_t;

endpackage

// File: rtl/adc_clk_src.sv
// Produces the undivided conversion-source strobe for the selected source.
// Assumes the alternate and asynchronous strobes are already synchronous to
// the bus clock. The half-rate phase is cleared while run_i is low, so the
// first half-rate strobe falls on the second cycle of a run.
module adc_clk_src
    import adc_seq_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     run_i,
    input  src_sel_e sel_i,
    input  logic     alt_tick_i,
    input  logic     async_tick_i,
    output logic     src_tick_o
);

    logic half_q;

    // Toggle the half-rate phase while running; park it at zero otherwise.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !run_i) begin
            half_q <= 1'b0;
        end else begin
            half_q <= ~half_q;
        end
    end

    // Route the chosen source and gate it with the run window.
    always_comb begin
        unique case (sel_i)
            SRC_BUS:   src_tick_o = run_i;
            SRC_HALF:  src_tick_o = run_i & half_q;
            SRC_ALT:   src_tick_o = run_i & alt_tick_i;
            default:   src_tick_o = run_i & async_tick_i;
        endcase
    end

    // The half-rate source never strobes on two cycles in a row.
    assert_half_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_tick_o && sel_i == SRC_HALF) |=> !(src_tick_o && sel_i == SRC_HALF));

endmodule

// File: rtl/adc_clk_div.sv
// Divides the source strobe by 2**div_sel_i to form conversion-clock ticks.
// Assumes the count is cleared outside a run, so the first tick comes after
// exactly one full ratio of source strobes.
module adc_clk_div
    import adc_seq_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 run_i,
    input  logic                 src_tick_i,
    input  logic [DIV_SEL_W-1:0] div_sel_i,
    output logic                 conv_tick_o
);

    localparam int CNT_W = (1 << DIV_SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;

    // Terminal count is ratio minus one.
    always_comb begin
        last_cnt    = (CNT_W'(1) << div_sel_i) - CNT_W'(1);
        conv_tick_o = run_i & src_tick_i & (cnt_q == last_cnt);
    end

    // Count source strobes and wrap at the terminal count.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !run_i) begin
            cnt_q <= '0;
        end else if (src_tick_i) begin
            cnt_q <= (cnt_q == last_cnt) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // With a ratio above one, conversion ticks never come back to back.
    assert_div_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (conv_tick_o && div_sel_i != '0) |=> !conv_tick_o);

endmodule

// File: rtl/adc_seq_ctrl.sv
// Start, abort, synchronisation and period counting for each conversion.
// Assumes the conversion tick comes from the divider fed by cfg_o. The
// settings are captured at each start edge, and continuous mode is read at
// each done edge.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int SMP_W       = 12,
    parameter int FIRST_TICKS = 23,
    parameter int LONG_TICKS  = 40,
    parameter int SHORT_TICKS = 20,
    parameter int SYNC_CYCLES = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  conv_cfg_t        cfg_i,
    input  logic             wait_i,
    input  logic             alt_wait_ok_i,
    input  logic             cont_i,
    input  logic             hw_trig_en_i,
    input  logic             chan_valid_i,
    input  logic             ctrl_wr_i,
    input  logic             trig_i,
    input  logic             conv_tick_i,
    input  logic [SMP_W-1:0] sample_i,
    output conv_cfg_t        cfg_o,
    output logic             run_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [SMP_W-1:0] result_o
);

    localparam int MAX_A = (FIRST_TICKS > LONG_TICKS) ? FIRST_TICKS : LONG_TICKS;
    localparam int MAX_T = (MAX_A > SHORT_TICKS) ? MAX_A : SHORT_TICKS;
    localparam int TW    = $clog2(MAX_T + 1);
    localparam int SW    = $clog2(SYNC_CYCLES + 1);

    seq_state_e       state_q;
    conv_cfg_t        cfg_q;
    logic [SW-1:0]    sync_q;
    logic [TW-1:0]    tick_q;
    logic [TW-1:0]    len;
    logic             first_q;
    logic             done_q;
    logic [SMP_W-1:0] res_q;
    logic             sw_start;
    logic             abort;
    logic             hw_start;
    logic             chain_ok;

    // Decode the start and abort events and the wait-mode source gating.
    always_comb begin
        sw_start = ctrl_wr_i & ~wait_i & chan_valid_i & ~hw_trig_en_i;
        abort    = ctrl_wr_i & ~wait_i & (state_q != ST_IDLE);
        hw_start = hw_trig_en_i & trig_i & chan_valid_i & (state_q == ST_IDLE)
                 & (~wait_i | (cfg_i.src != SRC_ALT) | alt_wait_ok_i);
        chain_ok = ~wait_i | (cfg_q.src != SRC_ALT) | alt_wait_ok_i;
        if (first_q) begin
            len = TW'(FIRST_TICKS);
        end else if (cfg_q.long_smp) begin
            len = TW'(LONG_TICKS);
        end else begin
            len = TW'(SHORT_TICKS);
        end
    end

    // Sequence state: start, abort, synchronisation window, period counting.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            sync_q  <= '0;
            tick_q  <= '0;
            first_q <= 1'b1;
            done_q  <= 1'b0;
            res_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (sw_start || (!abort && hw_start)) begin
                state_q <= ST_SYNC;
                cfg_q   <= cfg_i;
                sync_q  <= '0;
                tick_q  <= '0;
                first_q <= 1'b1;
            end else if (abort) begin
                state_q <= ST_IDLE;
            end else begin
                unique case (state_q)
                    ST_SYNC: begin
                        if (sync_q == SW'(SYNC_CYCLES - 1)) begin
                            state_q <= ST_CONV;
                        end else begin
                            sync_q <= sync_q + SW'(1);
                        end
                    end
                    ST_CONV: begin
                        if (conv_tick_i) begin
                            if (tick_q == len - TW'(1)) begin
                                done_q  <= 1'b1;
                                res_q   <= sample_i;
                                tick_q  <= '0;
                                first_q <= 1'b0;
                                if (!(cont_i && chain_ok)) begin
                                    state_q <= ST_IDLE;
                                end
                            end else begin
                                tick_q <= tick_q + TW'(1);
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign cfg_o    = cfg_q;
    assign run_o    = (state_q == ST_CONV);
    assign busy_o   = (state_q != ST_IDLE);
    assign done_o   = done_q;
    assign result_o = res_q;

    // Done is a single-cycle pulse.
    assert_done_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // A write without a channel always leaves the block idle.
    assert_wr_nochan_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_wr_i && !wait_i && !chan_valid_i) |=> !busy_o);

    // Entering wait never cuts a running conversion short.
    assert_wait_keeps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && wait_i) |=> (busy_o || done_o));

    // In wait, an idle block only wakes on an enabled hardware trigger.
    assert_wait_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(busy_o) && $past(wait_i)) |-> $past(trig_i && hw_trig_en_i));

endmodule

// File: rtl/adc_conv_seq.sv
// Top of the conversion clock and sequencer: source select, divider and
// sequence control. Assumes all inputs are synchronous to clk_i. The
// converter itself is modelled by sample_i.
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int SMP_W       = 12,
    parameter int FIRST_TICKS = 23,
    parameter int LONG_TICKS  = 40,
    parameter int SHORT_TICKS = 20,
    parameter int SYNC_CYCLES = 5
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 alt_tick_i,
    input  logic                 async_tick_i,
    input  logic                 wait_i,
    input  logic                 alt_wait_ok_i,
    input  logic [1:0]           clk_sel_i,
    input  logic [DIV_SEL_W-1:0] div_sel_i,
    input  logic                 long_smp_i,
    input  logic                 cont_i,
    input  logic                 hw_trig_en_i,
    input  logic                 chan_valid_i,
    input  logic                 ctrl_wr_i,
    input  logic                 trig_i,
    input  logic [SMP_W-1:0]     sample_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [SMP_W-1:0]     result_o
);

    conv_cfg_t live_cfg;
    conv_cfg_t run_cfg;
    logic      run;
    logic      src_tick;
    logic      conv_tick;

    // Pack the live control fields for capture at the start edge.
    always_comb begin
        live_cfg.src      = src_sel_e'(clk_sel_i);
        live_cfg.div      = div_sel_i;
        live_cfg.long_smp = long_smp_i;
    end

    adc_clk_src u_src (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .run_i        (run),
        .sel_i        (run_cfg.src),
        .alt_tick_i   (alt_tick_i),
        .async_tick_i (async_tick_i),
        .src_tick_o   (src_tick)
    );

    adc_clk_div u_div (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .run_i       (run),
        .src_tick_i  (src_tick),
        .div_sel_i   (run_cfg.div),
        .conv_tick_o (conv_tick)
    );

    adc_seq_ctrl #(
        .SMP_W       (SMP_W),
        .FIRST_TICKS (FIRST_TICKS),
        .LONG_TICKS  (LONG_TICKS),
        .SHORT_TICKS (SHORT_TICKS),
        .SYNC_CYCLES (SYNC_CYCLES)
    ) u_ctrl (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .cfg_i         (live_cfg),
        .wait_i        (wait_i),
        .alt_wait_ok_i (alt_wait_ok_i),
        .cont_i        (cont_i),
        .hw_trig_en_i  (hw_trig_en_i),
        .chan_valid_i  (chan_valid_i),
        .ctrl_wr_i     (ctrl_wr_i),
        .trig_i        (trig_i),
        .conv_tick_i   (conv_tick),
        .sample_i      (sample_i),
        .cfg_o         (run_cfg),
        .run_o         (run),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .result_o      (result_o)
    );

endmodule

// File: tb/adc_conv_seq_tb.sv
module adc_conv_seq_tb;

    localparam int SMP_W = 12;
    localparam int NV    = 16;
    // sel, div, sample, expected done edge after start
    localparam int VEC [NV][4] = '{
        '{0, 0, 'h101,  28}, '{0, 1, 'h202,  51}, '{0, 2, 'h303,  97}, '{0, 3, 'h404, 189},
        '{1, 0, 'h505,  51}, '{1, 1, 'h606,  97}, '{1, 2, 'h707, 189}, '{1, 3, 'h808, 373},
        '{2, 0, 'h909,  72}, '{2, 1, 'hA0A, 141}, '{2, 2, 'hB0B, 279}, '{2, 3, 'hC0C, 555},
        '{3, 0, 'hD0D, 120}, '{3, 1, 'hE0E, 235}, '{3, 2, 'hF0F, 465}, '{3, 3, 'h0F1, 925}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic wait_m = 1'b0, alt_ok = 1'b0, long_smp = 1'b0, cont = 1'b0;
    logic hw_en = 1'b0, chan_ok = 1'b1, wr = 1'b0, trig = 1'b0;
    logic [1:0] csel = 2'd0, dsel = 2'd0;
    logic [SMP_W-1:0] sample = '0;
    logic alt_tk, async_tk, busy, done;
    logic [SMP_W-1:0] result;

    int rel = 0;
    int errors = 0;
    int checks = 0;

    // Edge count since the last write or trigger; strobes are tied to it.
    always @(posedge clk) rel <= (wr || trig) ? 0 : rel + 1;
    assign alt_tk   = ((rel + 1) % 3) == 0;
    assign async_tk = ((rel + 1) % 5) == 0;

    adc_conv_seq u_dut (
        .clk_i(clk), .rst_ni(rst_n), .alt_tick_i(alt_tk), .async_tick_i(async_tk),
        .wait_i(wait_m), .alt_wait_ok_i(alt_ok), .clk_sel_i(csel), .div_sel_i(dsel),
        .long_smp_i(long_smp), .cont_i(cont), .hw_trig_en_i(hw_en),
        .chan_valid_i(chan_ok), .ctrl_wr_i(wr), .trig_i(trig), .sample_i(sample),
        .busy_o(busy), .done_o(done), .result_o(result)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit strobe(input int sel, input int c);
        case (sel)
            0:       return 1'b1;
            1:       return ((c - 5) % 2) == 0;
            2:       return (c % 3) == 0;
            default: return (c % 5) == 0;
        endcase
    endfunction

    // Edge at which the n-th source strobe after edge 'from' occurs.
    function automatic int edge_of(input int sel, input int from, input int n);
        int c = from;
        int k = 0;
        while (k < n) begin
            c++;
            if (strobe(sel, c)) k++;
        end
        return c;
    endfunction

    task automatic pulse_wr();
        @(negedge clk); wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
    endtask

    task automatic wait_done(input int limit, output int at);
        at = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (done) begin
                at = rel;
                break;
            end
        end
    endtask

    task automatic wait_rel(input int target);
        while (rel < target) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog: actual=timeout expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int at;
        int exp;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 busy after reset", int'(busy), 0);
        chk("R11 done after reset", int'(done), 0);
        chk("R11 result after reset", int'(result), 0);

        // R1 R2 R4 R5: every source and divide pair, single conversion
        for (int v = 0; v < NV; v++) begin
            csel = 2'(VEC[v][0]);
            dsel = 2'(VEC[v][1]);
            sample = SMP_W'(VEC[v][2]);
            pulse_wr();
            chk("R5 busy after write", int'(busy), 1);
            wait_done(1200, at);
            chk($sformatf("R1 R2 latency sel=%0d div=%0d", VEC[v][0], VEC[v][1]), at, VEC[v][3]);
            chk("R4 result captured", int'(result), VEC[v][2]);
            @(negedge clk);
            chk("R4 done one cycle", int'(done), 0);
            chk("R4 result held", int'(result), VEC[v][2]);
            chk("R2 idle after single", int'(busy), 0);
        end

        // R3: continuous with long sampling on the bus clock
        csel = 2'd0; dsel = 2'd0; long_smp = 1'b1; cont = 1'b1; sample = 12'h3C3;
        pulse_wr();
        wait_done(200, at);
        chk("R3 first of chain", at, 28);
        wait_done(200, at);
        chk("R3 long follow-on", at, 68);
        cont = 1'b0;
        wait_done(200, at);
        chk("R3 last of chain", at, 108);
        @(negedge clk);
        chk("R3 idle when continuous off", int'(busy), 0);

        // R3: continuous with short sampling on half the bus clock
        csel = 2'd1; long_smp = 1'b0; cont = 1'b1;
        pulse_wr();
        wait_done(200, at);
        exp = edge_of(1, 5, 23);
        chk("R3 half-rate first", at, exp);
        wait_done(200, at);
        exp = edge_of(1, exp, 20);
        chk("R3 short follow-on", at, exp);
        cont = 1'b0;
        wait_done(200, at);
        exp = edge_of(1, exp, 20);
        chk("R3 short last", at, exp);

        // R12: changing settings mid-run does not retime it
        csel = 2'd0; dsel = 2'd0;
        pulse_wr();
        wait_rel(3);
        csel = 2'd3; dsel = 2'd3;
        wait_done(300, at);
        chk("R12 captured settings", at, 28);
        csel = 2'd0; dsel = 2'd0;

        // R6: abort and restart
        pulse_wr();
        wait_rel(10);
        pulse_wr();
        wait_done(200, at);
        chk("R6 restart from zero", at, 28);
        // R6: abort to idle without a channel
        pulse_wr();
        wait_rel(10);
        chan_ok = 1'b0;
        pulse_wr();
        chk("R6 idle after abort", int'(busy), 0);
        wait_done(80, at);
        chk("R6 no done after abort", at, -1);
        chan_ok = 1'b1;

        // R7: hardware trigger mode
        hw_en = 1'b1;
        pulse_wr();
        chk("R7 write ignored in trigger mode", int'(busy), 0);
        sample = 12'h5A5;
        pulse_trig();
        chk("R7 trigger starts", int'(busy), 1);
        wait_done(200, at);
        chk("R7 trigger latency", at, 28);
        chk("R7 trigger result", int'(result), 'h5A5);
        hw_en = 1'b0;

        // R8: wait entered mid-conversion
        dsel = 2'd3;
        pulse_wr();
        wait_rel(20);
        wait_m = 1'b1;
        wait_done(400, at);
        chk("R8 completes through wait", at, 189);
        @(negedge clk);
        chk("R8 idle after", int'(busy), 0);
        dsel = 2'd0;

        // R9: writes ignored in wait, trigger still works
        pulse_wr();
        chk("R9 write ignored in wait", int'(busy), 0);
        wait_done(60, at);
        chk("R9 no done from write", at, -1);
        hw_en = 1'b1;
        pulse_trig();
        wait_done(200, at);
        chk("R9 trigger in wait", at, 28);

        // R10: alternate source in wait
        csel = 2'd2; alt_ok = 1'b0;
        pulse_trig();
        chk("R10 alt blocked in wait", int'(busy), 0);
        wait_done(200, at);
        chk("R10 no done when blocked", at, -1);
        alt_ok = 1'b1;
        pulse_trig();
        wait_done(200, at);
        chk("R10 alt allowed in wait", at, 72);
        // R10 and R3: chain in wait stops when alternate use is withdrawn
        cont = 1'b1; long_smp = 1'b1;
        pulse_trig();
        wait_done(200, at);
        chk("R10 chain first", at, 72);
        alt_ok = 1'b0;
        wait_done(300, at);
        exp = edge_of(2, 72, 40);
        chk("R10 chain second", at, exp);
        @(negedge clk);
        chk("R10 chain ends", int'(busy), 0);
        cont = 1'b0; wait_m = 1'b0; hw_en = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule